// File: doc/BRIEF.md
# Serial PHY Link and Collision Status Scanner

This block sits next to a switch device and reports the link and collision state of a row of PHYs over two shared serial lines, both timed by the scan clock. The switch owns the lines while idle and marks the start of each scan period by pulling them low for a fixed run of cycles. The block watches for that start mark. When it sees one, it takes over the lines and shifts out one link bit per port on the link line, followed by a single polarity bit. It also shifts out one collision bit per port on the collision line. The block then releases both lines for the rest of the 32-cycle period, so the switch can send the next start mark.

The per-port link and collision inputs, and the polarity strap, pass through a synchroniser into the scan clock domain. They are captured in one snapshot on the cycle the start mark completes, so every bit of a period describes the same instant. The sequencer has four states:

- `ST_HUNT`: lines released, waiting for a mark.
- `ST_BOTH`: both lines driven, one port per cycle.
- `ST_POLTAIL`: only the link line driven, carrying the polarity bit.
- `ST_GAP`: lines released until the period ends.

The transitions are:

- T_SIG: `ST_HUNT` to `ST_BOTH` on a mark.
- T_LAST_PORT: `ST_BOTH` to `ST_POLTAIL` after the last port.
- T_POL_DONE: `ST_POLTAIL` to `ST_GAP`.
- T_RESYNC: `ST_GAP` to `ST_BOTH` on a mark. This covers both a mark that ends exactly at the end of the period and one that ends early, which aborts the remainder and restarts the count.
- T_TIMEOUT: `ST_GAP` to `ST_HUNT` when the period ends with no mark.

Top module: `scan_status_tx`

## Requirements
- R1: While reset is asserted, both output enables and both serial data outputs are 0.
- R2: A cycle counts toward the start mark only after the detector is armed. It is armed by a cycle in which the lines are not low, or by a cycle in which the block drives the collision line. Seven counted cycles in a row make a mark. Lines held low since reset, or a run of six broken by a high cycle, start nothing.
- R3: In the cycle after the seventh counted cycle, both enables are 1. In cycle k of the sequence (k = 0 .. NPORT-1), the link line carries the link bit of port k, port 0 first.
- R4: In cycle NPORT the link line carries the polarity bit: 1 when the strap says the link signal is active high, 0 otherwise. The collision line is released in that cycle.
- R5: In cycle k (k = 0 .. NPORT-1) the collision line carries the collision bit of port k, port 0 first.
- R6: The link enable is 1 for exactly NPORT+1 cycles and the collision enable for exactly NPORT cycles. Both are 0 from cycle NPORT+1 to the end of the 32-cycle period. A serial output is 0 whenever its enable is 0.
- R7: All bits of one sequence come from the synchronised inputs as captured when the mark completes. Input changes during the sequence do not appear in it.
- R8: A cycle counts toward a mark only when the collision line is released and low, and the link line is either driven by the block or low. A released link line that is high breaks the run.
- R9: A mark that completes before the period ends aborts the rest of the period. A new sequence then starts in the next cycle with its count at 0.
- R10: If no mark completes by the last cycle of the period, the block returns to hunting with both lines released. A later mark still starts a full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| phy_link | input | NPORT | Per-port link status, asynchronous |
| phy_col | input | NPORT | Per-port collision status, asynchronous |
| link_pol_high | input | 1 | Strap: 1 when link signals are active high |
| link_line_in | input | 1 | Sampled value of the link line |
| col_line_in | input | 1 | Sampled value of the collision line |
| link_line_out | output | 1 | Serial data driven onto the link line |
| link_line_oe | output | 1 | Drive enable for the link line |
| col_line_out | output | 1 | Serial data driven onto the collision line |
| col_line_oe | output | 1 | Drive enable for the collision line |

## Verification
The assertions watch on every cycle for several conditions:

- the sequencer entering its first data cycle right after a detected mark;
- the collision line being released one cycle before the link line;
- the link line being released one cycle later;
- released lines carrying 0;
- no mark being recognised while the collision line is driven;
- the run counter staying in range.

Some behaviours only the bench scenarios can show:

- the serial bit order and polarity values across several port patterns;
- that the snapshot ignores inputs changing mid-sequence;
- that an early mark restarts the count one cycle sooner;
- that lines low from reset, broken runs, and a high link line start nothing;
- the return to hunting after a period with no mark.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int DEF_NPORT     = 24;
    localparam int DEF_FRAME_LEN = 32;
    localparam int DEF_SIG_LEN   = 7;
    localparam int DEF_SYNC_STG  = 2;

    // Sequencer states of one scan period
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_BOTH    = 2'd1,
        ST_POLTAIL = 2'd2,
        ST_GAP     = 2'd3
    } scan_st_e;

endpackage

// File: rtl/scan_sync.sv
module scan_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/scan_sig_detect.sv
module scan_sig_detect #(
    parameter int SIG_LEN = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_line_in,
    input  logic col_line_in,
    input  logic link_oe,
    input  logic col_oe,
    output logic sig_hit
);

    localparam int RUN_W = $clog2(SIG_LEN + 1);

    logic             armed_q;
    logic [RUN_W-1:0] run_q;
    logic             listen;
    logic             low_cyc;

    // The collision line must be ours to watch; a link line we drive is ignored
    assign listen  = !col_oe;
    assign low_cyc = listen && !col_line_in && (link_oe || !link_line_in);
    assign sig_hit = low_cyc && armed_q && (run_q == RUN_W'(SIG_LEN - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            run_q   <= '0;
        end else if (!listen || !low_cyc) begin
            // idle or own drive re-arms and clears the run
            armed_q <= 1'b1;
            run_q   <= '0;
        end else if (armed_q) begin
            if (sig_hit) begin
                armed_q <= 1'b0;
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q < RUN_W'(SIG_LEN)); // R2

    AST_DISARMED_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> run_q == '0); // R2

endmodule

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
    import scan_pkg::*;
#(
    parameter int NPORT     = 24,
    parameter int FRAME_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_hit,
    output logic link_oe,
    output logic col_oe
);

    localparam int CNT_W = $clog2(FRAME_LEN);

    scan_st_e         st_q, st_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_HUNT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nx;
            cnt_q <= cnt_nx;
        end
    end

    // Next state
    always_comb begin
        st_nx  = st_q;
        cnt_nx = cnt_q + 1'b1;
        unique case (st_q)
            ST_HUNT: begin
                cnt_nx = '0;
            end
            ST_BOTH: begin
                if (cnt_q == CNT_W'(NPORT - 1)) st_nx = ST_POLTAIL; // T_LAST_PORT
            end
            ST_POLTAIL: begin
                st_nx = ST_GAP;                                      // T_POL_DONE
            end
            ST_GAP: begin
                if (cnt_q == CNT_W'(FRAME_LEN - 1)) begin           // T_TIMEOUT
                    st_nx  = ST_HUNT;
                    cnt_nx = '0;
                end
            end
            default: begin
                st_nx  = ST_HUNT;
                cnt_nx = '0;
            end
        endcase
        if (sig_hit) begin                                           // T_SIG / T_RESYNC
            st_nx  = ST_BOTH;
            cnt_nx = '0;
        end
    end

    // Outputs
    always_comb begin
        link_oe = 1'b0;
        col_oe  = 1'b0;
        unique case (st_q)
            ST_HUNT:    begin link_oe = 1'b0; col_oe = 1'b0; end
            ST_BOTH:    begin link_oe = 1'b1; col_oe = 1'b1; end
            ST_POLTAIL: begin link_oe = 1'b1; col_oe = 1'b0; end
            ST_GAP:     begin link_oe = 1'b0; col_oe = 1'b0; end
            default:    begin link_oe = 1'b0; col_oe = 1'b0; end
        endcase
    end

    AST_START_AFTER_SIG: assert property (@(posedge clk) disable iff (!rst_n)
        sig_hit |=> (link_oe && col_oe && cnt_q == '0)); // R3

    AST_COL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (col_oe && cnt_q == CNT_W'(NPORT - 1)) |=> (!col_oe && link_oe)); // R5

    AST_LINK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (link_oe && !col_oe) |=> !link_oe); // R6

    AST_GAP_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_GAP) |-> cnt_q > CNT_W'(NPORT)); // R6

endmodule

// File: rtl/scan_shift.sv
module scan_shift #(
    parameter int NPORT = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NPORT-1:0] link_s,
    input  logic [NPORT-1:0] col_s,
    input  logic             pol_s,
    input  logic             link_oe,
    input  logic             col_oe,
    output logic             link_out,
    output logic             col_out
);

    logic [NPORT:0]   link_sh_q;   // polarity bit sits above the last port
    logic [NPORT-1:0] col_sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_sh_q <= '0;
            col_sh_q  <= '0;
        end else if (load) begin
            link_sh_q <= {pol_s, link_s};
            col_sh_q  <= col_s;
        end else begin
            if (link_oe) link_sh_q <= link_sh_q >> 1;
            if (col_oe)  col_sh_q  <= col_sh_q >> 1;
        end
    end

    assign link_out = link_oe & link_sh_q[0];
    assign col_out  = col_oe & col_sh_q[0];

    AST_FIRST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (link_out == $past(link_s[0]) && col_out == $past(col_s[0]))); // R3

endmodule

// File: rtl/scan_status_tx.sv
module scan_status_tx
    import scan_pkg::*;
#(
    parameter int NPORT     = DEF_NPORT,
    parameter int FRAME_LEN = DEF_FRAME_LEN,
    parameter int SIG_LEN   = DEF_SIG_LEN,
    parameter int SYNC_STG  = DEF_SYNC_STG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] phy_link,
    input  logic [NPORT-1:0] phy_col,
    input  logic             link_pol_high,
    input  logic             link_line_in,
    input  logic             col_line_in,
    output logic             link_line_out,
    output logic             link_line_oe,
    output logic             col_line_out,
    output logic             col_line_oe
);

    localparam int SYNC_W = 2 * NPORT + 1;

    logic [SYNC_W-1:0] sync_q;
    logic [NPORT-1:0]  link_s, col_s;
    logic              pol_s;
    logic              sig_hit;

    scan_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({link_pol_high, phy_col, phy_link}),
        .q     (sync_q)
    );

    assign link_s = sync_q[NPORT-1:0];
    assign col_s  = sync_q[2*NPORT-1:NPORT];
    assign pol_s  = sync_q[SYNC_W-1];

    scan_sig_detect #(.SIG_LEN(SIG_LEN)) u_det (
        .clk          (clk),
        .rst_n        (rst_n),
        .link_line_in (link_line_in),
        .col_line_in  (col_line_in),
        .link_oe      (link_line_oe),
        .col_oe       (col_line_oe),
        .sig_hit      (sig_hit)
    );

    scan_seq_fsm #(.NPORT(NPORT), .FRAME_LEN(FRAME_LEN)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig_hit (sig_hit),
        .link_oe (link_line_oe),
        .col_oe  (col_line_oe)
    );

    scan_shift #(.NPORT(NPORT)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sig_hit),
        .link_s   (link_s),
        .col_s    (col_s),
        .pol_s    (pol_s),
        .link_oe  (link_line_oe),
        .col_oe   (col_line_oe),
        .link_out (link_line_out),
        .col_out  (col_line_out)
    );

    AST_LINK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !link_line_oe |-> !link_line_out); // R6

    AST_COL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !col_line_oe |-> !col_line_out); // R6

    AST_NO_HIT_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        col_line_oe |-> !sig_hit); // R8

endmodule

// File: tb/sim_scan_status_tx.sv
module sim_scan_status_tx;

    localparam int NP = 24;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] phy_link, phy_col;
    logic          pol;
    logic          sw_link, sw_col;
    logic          link_out, link_oe, col_out, col_oe;
    logic          link_line, col_line;

    always #5 clk = ~clk;

    // Shared line model: the block wins while enabled, otherwise the switch side
    assign link_line = link_oe ? link_out : sw_link;
    assign col_line  = col_oe  ? col_out  : sw_col;

    scan_status_tx #(.NPORT(NP)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .phy_link      (phy_link),
        .phy_col       (phy_col),
        .link_pol_high (pol),
        .link_line_in  (link_line),
        .col_line_in   (col_line),
        .link_line_out (link_out),
        .link_line_oe  (link_oe),
        .col_line_out  (col_out),
        .col_line_oe   (col_oe)
    );

    typedef struct {
        logic [3:0] v;    // {link_oe, link_out, col_oe, col_out}
        string      req;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // Driver side: expected serial tuples of one sequence
    task automatic push_frame(input logic [NP-1:0] lk, input logic [NP-1:0] cl, input logic pl);
        for (int k = 0; k < NP; k++) begin
            exp_t e;
            e.v   = {1'b1, lk[k], 1'b1, cl[k]};
            e.req = "R3/R5 port bit";
            q.push_back(e);
        end
        begin
            exp_t e;
            e.v   = {1'b1, pl, 1'b0, 1'b0};
            e.req = "R4 polarity bit";
            q.push_back(e);
        end
    endtask

    // Monitor: every driven cycle must match the next queued tuple
    always @(negedge clk) begin
        if (rst_n && (link_oe || col_oe)) begin
            if (q.size() == 0) begin
                chk(1'b0, "R6 unexpected drive", {28'd0, link_oe, link_out, col_oe, col_out}, 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk({link_oe, link_out, col_oe, col_out} == e.v, e.req,
                    {28'd0, link_oe, link_out, col_oe, col_out}, {28'd0, e.v});
            end
        end
    end

    task automatic quiet(input int n, input string req);
        repeat (n) begin
            @(negedge clk);
            chk(!link_oe && !col_oe && !link_out && !col_out, req,
                {28'd0, link_oe, link_out, col_oe, col_out}, 32'd0);
        end
    endtask

    // Seven low cycles; returns at the negedge where cycle 0 is visible
    task automatic send_sig();
        repeat (7) begin
            @(negedge clk);
            sw_link = 1'b0;
            sw_col  = 1'b0;
        end
        @(negedge clk);
        sw_link = 1'b1;
        sw_col  = 1'b1;
    endtask

    task automatic chk_released(input string req);
        chk(!link_oe && !col_oe, req, {30'd0, link_oe, col_oe}, 32'd0);
        chk(q.size() == 0, req, q.size(), 32'd0);
    endtask

    initial begin
        #(200000 * 10);
        chk(1'b0, "watchdog", 32'd1, 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sw_link = 1'b0; sw_col = 1'b0;
        phy_link = '0; phy_col = '0; pol = 1'b1;
        repeat (3) @(negedge clk);
        chk(!link_oe && !col_oe && !link_out && !col_out, "R1 reset outputs",
            {28'd0, link_oe, link_out, col_oe, col_out}, 32'd0);
        rst_n = 1'b1;
        // R2: lines low since reset never count as a mark
        quiet(20, "R2 low since reset");
        sw_link = 1'b1; sw_col = 1'b1;
        quiet(3, "R2 idle");

        // Sequence A from hunt, polarity active high
        phy_link = 24'hA5C30F; phy_col = 24'h3C96E1; pol = 1'b1;
        repeat (4) @(negedge clk);
        push_frame(24'hA5C30F, 24'h3C96E1, 1'b1);
        send_sig();
        chk(link_oe && col_oe, "R3 drive starts after mark", {30'd0, link_oe, col_oe}, 32'd3);
        repeat (NP + 1) @(negedge clk);
        chk_released("R6 release at cycle 25");

        // Sequence B: mark in cycles 25..31, restart on the period boundary
        phy_link = 24'h0F0F55; phy_col = 24'hF00A5A; pol = 1'b0;
        push_frame(24'h0F0F55, 24'hF00A5A, 1'b0);
        sw_link = 1'b0; sw_col = 1'b0;
        repeat (7) @(negedge clk);
        sw_link = 1'b1; sw_col = 1'b1;
        chk(link_oe && col_oe, "R3 restart after boundary mark", {30'd0, link_oe, col_oe}, 32'd3);
        // R7: change inputs mid-sequence; B must still carry its snapshot
        repeat (5) @(negedge clk);
        phy_link = 24'hFFFFFF; phy_col = 24'h000001; pol = 1'b1;
        push_frame(24'hFFFFFF, 24'h000001, 1'b1);
        // R8/R9: early mark from cycle 24 while link still driven by the block
        repeat (19) @(negedge clk);
        sw_link = 1'b0; sw_col = 1'b0;
        repeat (7) @(negedge clk);
        sw_link = 1'b1; sw_col = 1'b1;
        chk(link_oe && col_oe, "R9 early mark restarts at cycle 31", {30'd0, link_oe, col_oe}, 32'd3);
        repeat (NP + 1) @(negedge clk);
        chk_released("R6 release after aborted period");

        // R8: collision low but released link line high never counts
        sw_col = 1'b0; sw_link = 1'b1;
        quiet(7, "R8 link high breaks mark");
        sw_col = 1'b1;
        // R10: period ends without a mark, block hunts with lines released
        quiet(30, "R10 hunt after timeout");

        // R2: a run of six broken by a high cycle
        repeat (6) begin @(negedge clk); sw_link = 1'b0; sw_col = 1'b0; end
        @(negedge clk); sw_link = 1'b1; sw_col = 1'b1;
        repeat (6) begin @(negedge clk); sw_link = 1'b0; sw_col = 1'b0; end
        @(negedge clk); sw_link = 1'b1; sw_col = 1'b1;
        quiet(20, "R2 broken run");

        // R10: a later mark still starts a full sequence
        phy_link = 24'h800001; phy_col = 24'h7FFFFE; pol = 1'b0;
        repeat (4) @(negedge clk);
        push_frame(24'h800001, 24'h7FFFFE, 1'b0);
        send_sig();
        chk(link_oe && col_oe, "R10 mark after hunt", {30'd0, link_oe, col_oe}, 32'd3);
        repeat (NP + 1) @(negedge clk);
        chk_released("R6 release final");
        quiet(6, "R6 rest of period");

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule